// File: doc/BRIEF.md
# H-Bridge Dead-Time and Interlock Controller

This block is the clocked control logic that sits between a switching controller and the gate drivers of a two-leg H-bridge. Each leg has a low-side and a high-side command input and a matching pair of gate-enable outputs. Within a leg the two switches are never enabled together: the low command takes precedence over the high command. Any output that has to switch on waits a programmable number of clock cycles first. Any output that has to switch off does so on the next register stage.

Holding a leg's high command at 1 gives complementary (bistate) operation. The low command alone then alternates the two switches, and the dead time separates them. A disable input and a supply-undervoltage flag both block every output. Each leg also has its own high-side undervoltage flag, which holds back its high switch. When the global block lifts, and also once after reset, both low-side outputs produce a bootstrap refresh pulse. High-side drive is allowed only after that pulse.

All asynchronous inputs pass through two-flop synchronizers. The command inputs then go through a minimum-pulse filter. The dead time, the refresh window and the minimum pulse width are given in clock cycles on configuration inputs, which are registered once per cycle.

Top module: `hbridge_deadtime_ctrl`

## Requirements
- R1: While the synchronized disable input is 1, all gate outputs are 0. Outputs drop on the third clock edge after disable_in rises.
- R2: While the synchronized supply-undervoltage flag is 1, all gate outputs are 0.
- R3: In a leg with both commands at 1, the low output is 1 and the high output is 0. The two outputs of one leg are never 1 together.
- R4: In normal running, a leg with low=0 and high=0 has both outputs at 0. Low=1 enables only the low output. Low=0 with high=1 enables only the high output.
- R5: A leg's high-side undervoltage flag keeps that leg's high output at 0. It has no effect on the low output when the low command is 1.
- R6: Let M be the effective minimum pulse width and D the effective dead time. A command change that turns an output off shows at the output on clock edge 3+M after the input change. A change that turns an output on shows on edge 3+M+D.
- R7: A dead-time setting of 0 behaves as 1, and the same holds for the minimum pulse width and the refresh setting. Configuration inputs take effect one cycle after they are applied.
- R8: With the high command held at 1, toggling the low command alternates the leg's two outputs. Each switch-over leaves exactly D cycles with both outputs at 0.
- R9: When the global block (disable or supply undervoltage) lifts, a refresh window of Rf cycles follows, where Rf is the effective refresh setting. During it both low outputs are requested and the high outputs are held at 0. With D < Rf, each low output is 1 for Rf-D cycles. High drive resumes only after the window.
- R10: Bit 0 of every per-leg port is leg A and bit 1 is leg B. The legs respond independently to their own commands and high-side flags.
- R11: A command input change that lasts fewer than M cycles after synchronization does not reach the outputs.
- R12: During reset all outputs are 0. After reset the refresh sequence runs once, so both low outputs pulse from edge D+1 to edge Rf after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lo_cmd | input | N_LEGS | Low-side command per leg |
| hi_cmd | input | N_LEGS | High-side command per leg |
| disable_in | input | 1 | Global disable, 1 blocks all outputs |
| supply_uv | input | 1 | Supply undervoltage flag, 1 blocks all outputs |
| hs_uv | input | N_LEGS | High-side undervoltage flag per leg |
| dead_cfg | input | CNT_W | Turn-on dead time in cycles (0 acts as 1) |
| refresh_cfg | input | CNT_W | Refresh window length in cycles (0 acts as 1) |
| minpw_cfg | input | CNT_W | Minimum command pulse width in cycles (0 acts as 1) |
| lo_gate | output | N_LEGS | Low-side gate enable per leg |
| hi_gate | output | N_LEGS | High-side gate enable per leg |

## Verification
The bench builds the block with its defaults: two legs, 4-bit counters, dead time 3, refresh window 6 and minimum pulse width 2. The configuration inputs are driven to the same values. With these settings the refresh pulse is 3 cycles long and differs from the refresh window, so an off-by-one in either counter shows up. The filter delay of 2 makes a 1-cycle command glitch distinguishable from a 2-cycle pulse. Setting the dead time to 0 at run time exercises the clamp and shortens the bistate gap to a single cycle.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;

    // Release sequencer states.
    typedef enum logic [1:0] {
        SEQ_BLOCKED = 2'd0,
        SEQ_REFRESH = 2'd1,
        SEQ_RUN     = 2'd2
    } seq_e;

endpackage

// File: rtl/hbdt_sync.sv
module hbdt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;

endmodule

// File: rtl/hbdt_pulse_filter.sv
module hbdt_pulse_filter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s,
    input  logic [CW-1:0] minpw,
    output logic          f
);

    typedef struct packed {
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_st_t;

    flt_st_t     st_d, st_q;
    logic [CW:0] cnt_nxt;

    always_comb begin
        st_d    = st_q;
        cnt_nxt = {1'b0, st_q.cnt} + 1'b1;
        if (s != st_q.filt) begin
            if (cnt_nxt >= {1'b0, minpw}) begin
                st_d.filt = s;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = cnt_nxt[CW-1:0];
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign f = st_q.filt;

    // R11: the filtered level only moves after the input disagreed with it.
    a_r11_filter_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.filt != $past(st_q.filt)) |-> ($past(s) != $past(st_q.filt)));

endmodule

// File: rtl/hbdt_leg.sv
module hbdt_leg #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lo_f,
    input  logic          hi_f,
    input  logic          hs_uv,
    input  logic          blk,
    input  logic          refresh,
    input  logic          hs_hold,
    input  logic [CW-1:0] dead,
    output logic          lo_on,
    output logic          hi_on
);

    typedef struct packed {
        logic          on;
        logic [CW-1:0] cnt;
    } chan_t;

    typedef struct packed {
        chan_t lo;
        chan_t hi;
    } leg_st_t;

    leg_st_t st_d, st_q;
    logic    want_lo, want_hi;

    // Off at once; on only after the count reaches the dead time and the
    // opposite switch of the leg is off.
    function automatic chan_t advance(chan_t cur, logic want, logic opp_on,
                                      logic [CW-1:0] lim);
        chan_t nxt;
        nxt = cur;
        if (!want) begin
            nxt.on  = 1'b0;
            nxt.cnt = '0;
        end else if (!cur.on) begin
            if (cur.cnt >= lim) begin
                if (!opp_on) nxt.on = 1'b1;
            end else begin
                nxt.cnt = cur.cnt + 1'b1;
            end
        end
        return nxt;
    endfunction

    always_comb begin
        want_lo = !blk && (refresh || lo_f);
        want_hi = !blk && !hs_hold && !lo_f && hi_f && !hs_uv;
        st_d    = st_q;
        st_d.lo = advance(st_q.lo, want_lo, st_q.hi.on, dead);
        st_d.hi = advance(st_q.hi, want_hi, st_q.lo.on, dead);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_on = st_q.lo.on;
    assign hi_on = st_q.hi.on;

    // R3
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_on && hi_on));

    // R6: a switch turns on only after its partner was off a cycle earlier.
    a_r6_hi_after_lo_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_on) |-> $past(!lo_on));
    a_r6_lo_after_hi_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_on) |-> $past(!hi_on));

    // R1 and R2: a global block clears both outputs on the next edge.
    a_r1_block_clears: assert property (@(posedge clk) disable iff (!rst_n)
        blk |=> (!lo_on && !hi_on));

    // R5
    a_r5_hs_uv_holds_high: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_uv && !lo_f) |=> !hi_on);

endmodule

// File: rtl/hbridge_deadtime_ctrl.sv
module hbridge_deadtime_ctrl
    import hbdt_pkg::*;
#(
    parameter int N_LEGS      = 2,
    parameter int CNT_W       = 4,
    parameter int DEF_DEAD    = 3,
    parameter int DEF_REFRESH = 6,
    parameter int DEF_MINPW   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LEGS-1:0] lo_cmd,
    input  logic [N_LEGS-1:0] hi_cmd,
    input  logic              disable_in,
    input  logic              supply_uv,
    input  logic [N_LEGS-1:0] hs_uv,
    input  logic [CNT_W-1:0]  dead_cfg,
    input  logic [CNT_W-1:0]  refresh_cfg,
    input  logic [CNT_W-1:0]  minpw_cfg,
    output logic [N_LEGS-1:0] lo_gate,
    output logic [N_LEGS-1:0] hi_gate
);

    localparam int SYNC_W = 3 * N_LEGS + 2;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        seq_e             seq;
        logic [CNT_W-1:0] rcnt;
        logic [CNT_W-1:0] dead;
        logic [CNT_W-1:0] refr;
        logic [CNT_W-1:0] minpw;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [SYNC_W-1:0] sync_in, sync_out;
    logic [N_LEGS-1:0] lo_s, hi_s, hs_uv_s;
    logic              dis_s, vuv_s, blk;
    logic [CNT_W-1:0]  dead_eff, refr_eff, minpw_eff;
    logic              refresh, hs_hold;

    assign sync_in = {lo_cmd, hi_cmd, hs_uv, disable_in, supply_uv};

    hbdt_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_in),
        .q     (sync_out)
    );

    assign {lo_s, hi_s, hs_uv_s, dis_s, vuv_s} = sync_out;
    assign blk = dis_s | vuv_s;

    assign dead_eff  = (st_q.dead  == '0) ? ONE : st_q.dead;
    assign refr_eff  = (st_q.refr  == '0) ? ONE : st_q.refr;
    assign minpw_eff = (st_q.minpw == '0) ? ONE : st_q.minpw;

    assign refresh = (st_q.seq == SEQ_REFRESH);
    assign hs_hold = (st_q.seq != SEQ_RUN);

    always_comb begin
        st_d       = st_q;
        st_d.dead  = dead_cfg;
        st_d.refr  = refresh_cfg;
        st_d.minpw = minpw_cfg;
        case (st_q.seq)
            SEQ_BLOCKED: begin
                if (!blk) begin
                    st_d.seq  = SEQ_REFRESH;
                    st_d.rcnt = '0;
                end
            end
            SEQ_REFRESH: begin
                if (blk) begin
                    st_d.seq  = SEQ_BLOCKED;
                    st_d.rcnt = '0;
                end else if ({1'b0, st_q.rcnt} + 1'b1 >= {1'b0, refr_eff}) begin
                    st_d.seq  = SEQ_RUN;
                    st_d.rcnt = '0;
                end else begin
                    st_d.rcnt = st_q.rcnt + 1'b1;
                end
            end
            SEQ_RUN: begin
                if (blk) st_d.seq = SEQ_BLOCKED;
            end
            default: begin
                st_d.seq  = SEQ_BLOCKED;
                st_d.rcnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.seq   <= SEQ_REFRESH;
            st_q.rcnt  <= '0;
            st_q.dead  <= CNT_W'(DEF_DEAD);
            st_q.refr  <= CNT_W'(DEF_REFRESH);
            st_q.minpw <= CNT_W'(DEF_MINPW);
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
        logic lo_f, hi_f;

        hbdt_pulse_filter #(.CW(CNT_W)) u_flt_lo (
            .clk   (clk),
            .rst_n (rst_n),
            .s     (lo_s[g]),
            .minpw (minpw_eff),
            .f     (lo_f)
        );

        hbdt_pulse_filter #(.CW(CNT_W)) u_flt_hi (
            .clk   (clk),
            .rst_n (rst_n),
            .s     (hi_s[g]),
            .minpw (minpw_eff),
            .f     (hi_f)
        );

        hbdt_leg #(.CW(CNT_W)) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .lo_f    (lo_f),
            .hi_f    (hi_f),
            .hs_uv   (hs_uv_s[g]),
            .blk     (blk),
            .refresh (refresh),
            .hs_hold (hs_hold),
            .dead    (dead_eff),
            .lo_on   (lo_gate[g]),
            .hi_on   (hi_gate[g])
        );
    end

    // R9: no high-side drive until the refresh window has closed.
    a_r9_high_held_until_run: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.seq != SEQ_RUN) |=> (hi_gate == '0));

    // R9: a refresh window only follows a blocked state or reset.
    a_r9_refresh_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.seq == SEQ_REFRESH) |-> ($past(st_q.seq) == SEQ_BLOCKED));

endmodule

// File: tb/hbridge_deadtime_ctrl_bench.sv
`timescale 1ns/1ps
module hbridge_deadtime_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] lo_cmd = '0, hi_cmd = '0, hs_uv = '0;
    logic       disable_in = 1'b0, supply_uv = 1'b0;
    logic [3:0] dead_cfg = 4'd3, refresh_cfg = 4'd6, minpw_cfg = 4'd2;
    logic [1:0] lo_gate, hi_gate;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    hbridge_deadtime_ctrl u_hbridge_deadtime_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .lo_cmd      (lo_cmd),
        .hi_cmd      (hi_cmd),
        .disable_in  (disable_in),
        .supply_uv   (supply_uv),
        .hs_uv       (hs_uv),
        .dead_cfg    (dead_cfg),
        .refresh_cfg (refresh_cfg),
        .minpw_cfg   (minpw_cfg),
        .lo_gate     (lo_gate),
        .hi_gate     (hi_gate)
    );

    // {disable, supply_uv, hs_uv[1:0], lo[1:0], hi[1:0], exp_lo[1:0], exp_hi[1:0]}
    localparam logic [11:0] VEC [0:9] = '{
        12'b0_0_00_00_00_00_00,
        12'b0_0_00_01_00_01_00,
        12'b0_0_00_00_11_00_11,
        12'b0_0_00_11_11_11_00,
        12'b0_0_00_01_10_01_10,
        12'b0_0_01_00_11_00_10,
        12'b0_0_11_11_00_11_00,
        12'b1_0_00_11_11_00_00,
        12'b0_1_00_10_01_00_00,
        12'b0_0_00_10_01_10_01
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 1, 2: return "R4";
            3:       return "R3";
            4, 9:    return "R10";
            5, 6:    return "R5";
            7:       return "R1";
            default: return "R2";
        endcase
    endfunction

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [1:0] exp_lo, logic [1:0] exp_hi);
        checks++;
        if (lo_gate !== exp_lo || hi_gate !== exp_hi) begin
            fails++;
            $display("FAIL %s: lo=%b hi=%b, expected lo=%b hi=%b",
                     req, lo_gate, hi_gate, exp_lo, exp_hi);
        end
    endtask

    task automatic settle(logic [1:0] lo, logic [1:0] hi);
        @(negedge clk);
        lo_cmd = lo;
        hi_cmd = hi;
        edges(40);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R12: outputs low in reset, then one refresh pulse (edges 4..6).
        edges(4);
        check("R12 in reset", 2'b00, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        edges(3);
        check("R12 before refresh pulse", 2'b00, 2'b00);
        edges(1);
        check("R12 refresh pulse start", 2'b11, 2'b00);
        edges(2);
        check("R12 refresh pulse end", 2'b11, 2'b00);
        edges(1);
        check("R12 refresh pulse over", 2'b00, 2'b00);

        // Table walk: steady-state truth table.
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            disable_in = VEC[i][11];
            supply_uv  = VEC[i][10];
            hs_uv      = VEC[i][9:8];
            lo_cmd     = VEC[i][7:6];
            hi_cmd     = VEC[i][5:4];
            edges(40);
            check(vec_tag(i), VEC[i][3:2], VEC[i][1:0]);
        end

        // R6 / R8: bistate switch-over on leg A, leg B untouched (R10).
        settle(2'b00, 2'b11);
        check("R8 bistate high side", 2'b00, 2'b11);
        @(negedge clk);
        lo_cmd = 2'b01;
        edges(4);
        check("R6 no change before filter", 2'b00, 2'b11);
        edges(1);
        check("R6 immediate turn-off", 2'b00, 2'b10);
        edges(2);
        check("R8 dead gap", 2'b00, 2'b10);
        edges(1);
        check("R6 delayed turn-on", 2'b01, 2'b10);
        @(negedge clk);
        lo_cmd = 2'b00;
        edges(5);
        check("R8 low off", 2'b00, 2'b10);
        edges(2);
        check("R8 dead gap back", 2'b00, 2'b10);
        edges(1);
        check("R8 high back on", 2'b00, 2'b11);

        // R11: 1-cycle glitch is filtered, 2-cycle pulse passes.
        settle(2'b11, 2'b11);
        check("R11 setup", 2'b11, 2'b00);
        begin
            logic bad;
            bad = 1'b0;
            @(negedge clk);
            lo_cmd = 2'b10;
            edges(1);
            @(negedge clk);
            lo_cmd = 2'b11;
            for (int k = 0; k < 12; k++) begin
                edges(1);
                if (lo_gate !== 2'b11) bad = 1'b1;
            end
            checks++;
            if (bad) begin
                fails++;
                $display("FAIL R11: short glitch reached lo=%b, expected lo=11", lo_gate);
            end
        end
        @(negedge clk);
        lo_cmd = 2'b10;
        edges(1);
        @(negedge clk);
        edges(1);
        @(negedge clk);
        lo_cmd = 2'b11;
        edges(3);
        check("R11 two-cycle pulse passes", 2'b10, 2'b00);
        edges(4);
        check("R11 pulse recovery pending", 2'b10, 2'b00);
        edges(1);
        check("R11 pulse recovered", 2'b11, 2'b00);

        // R7: dead time 0 clamps to 1.
        @(negedge clk);
        dead_cfg = 4'd0;
        settle(2'b00, 2'b11);
        check("R7 setup", 2'b00, 2'b11);
        @(negedge clk);
        lo_cmd = 2'b01;
        edges(5);
        check("R7 one-cycle gap", 2'b00, 2'b10);
        edges(1);
        check("R7 clamped turn-on", 2'b01, 2'b10);
        @(negedge clk);
        dead_cfg = 4'd3;
        settle(2'b00, 2'b11);

        // R1 / R9: disable, then refresh window on release.
        @(negedge clk);
        disable_in = 1'b1;
        edges(2);
        check("R1 before sync", 2'b00, 2'b11);
        edges(1);
        check("R1 disable clears", 2'b00, 2'b00);
        edges(10);
        @(negedge clk);
        disable_in = 1'b0;
        edges(6);
        check("R9 refresh pending", 2'b00, 2'b00);
        edges(1);
        check("R9 refresh pulse on", 2'b11, 2'b00);
        edges(2);
        check("R9 refresh last cycle", 2'b11, 2'b00);
        edges(1);
        check("R9 refresh pulse off", 2'b00, 2'b00);
        edges(2);
        check("R9 high held in dead gap", 2'b00, 2'b00);
        edges(1);
        check("R9 high resumes", 2'b00, 2'b11);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule